// File: doc/BRIEF.md
# Scripted Power Sequencer Engine

This block runs short power-transition programs that are kept in a small internal instruction store. Each instruction occupies four consecutive bytes. The first two bytes form a 16-bit resource message. The third is a delay counted in slow-clock ticks. The fourth is the index of the following instruction. Four trigger events each own a start pointer into the store: going to sleep, waking processor groups one and two, waking group three, and warm reset. When a trigger fires, the engine follows the chain that begins at that event's pointer. For each instruction it presents the message with a one-cycle strobe, waits out the delay and then moves to the next index, until it reaches the end marker.

A host fills the store and the pointers through a narrow register write port. It first places a byte address in an address register and then writes bytes to a data register, and the address advances by one after every data byte. The pointers, the address register and the data register only accept writes after a two-value unlock sequence has been written to a key register. The slow clock arrives as a single-cycle enable `tick` in the fast clock domain. Turning messages into regulator actions belongs to a downstream block.

Top module: `pwr_script_seq`

## Requirements
- R1: After reset the engine is idle: `busy`, `msg_valid`, `done` and `err_flag` are all 0. The key register is locked, and all four start pointers hold the end marker 0x3F.
- R2: Register offsets are 0 key, 1 memory address, 2 memory data, 3 to 6 start pointers, 7 error clear. A key write of 0xA5 moves the lock to half-open. A key write of 0x5A while half-open opens it. Any other key write, including 0, locks it. Writes to offsets 1 to 6 are ignored unless the lock is open.
- R3: A data write stores its byte at the current memory address, and the address then advances by one. Instruction `i` occupies bytes 4i to 4i+3, holding in order the message high byte, the message low byte, the delay and the next index.
- R4: Trigger bits are 0 sleep, 1 wake groups 1/2, 2 wake group 3, and 3 warm reset. When a trigger is seen while idle, that event's start pointer is latched. If more than one bit is set, the highest bit wins and `err_flag` is set.
- R5: Each instruction is emitted as `msg_valid`=1 for exactly one cycle, with `msg_data` = {high byte, low byte}. The first instruction is emitted in the cycle after the trigger is sampled.
- R6: For an instruction with delay D, the next instruction (or `done`) follows the (D+1)th tick that occurs after the emission cycle. A tick in the emission cycle itself is not counted.
- R7: Only the low six bits of a next index are used. The value 0x3F ends the script, and `done` then pulses for one cycle in the cycle after the final tick.
- R8: If the latched start pointer is 0x3F, `done` pulses in the cycle after the trigger and no message is emitted.
- R9: A trigger that arrives while busy is ignored and the running script continues unchanged. Such a trigger sets the sticky `err_flag`. Any write to offset 7 clears the flag whether or not the lock is open. When a clear and a new error fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host register offset |
| wr_data | input | 8 | Host write data |
| tick | input | 1 | Slow-clock enable, one fast cycle wide |
| trig | input | 4 | Event trigger pulses |
| msg_valid | output | 1 | Resource message strobe |
| msg_data | output | 16 | Resource message |
| busy | output | 1 | A script is being run |
| done | output | 1 | One-cycle pulse when a script ends |
| err_flag | output | 1 | Sticky trigger-while-busy error |

## Verification
Two functions can fall in the same cycle: a slow tick arriving in the cycle that emits a message, and an error-clear write arriving in the cycle that a busy-time trigger raises a new error. The free-running tick has a period of three cycles, so across the delay sweep ticks land in emission cycles as well as in wait cycles. The bench counts the ticks between strobes and compares them with delay plus one. For the error case, the bench drives the clear write and the intruding trigger in the same cycle and expects the flag to stay set, while the script's messages and gaps match the unchanged chain.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int REG_AW = 3;
  localparam int NEV    = 4;

  localparam logic [REG_AW-1:0] RA_KEY    = 3'd0;
  localparam logic [REG_AW-1:0] RA_MADDR  = 3'd1;
  localparam logic [REG_AW-1:0] RA_MDATA  = 3'd2;
  localparam int                RA_PTR0   = 3;
  localparam logic [REG_AW-1:0] RA_ERRCLR = 3'd7;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_e;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_EMIT = 2'd1,
    ENG_WAIT = 2'd2,
    ENG_FIN  = 2'd3
  } eng_e;
endpackage

// File: rtl/pss_imem.sv
module pss_imem #(
  parameter int IDX_W = 6,
  parameter int BYTE_W = 8
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [IDX_W+1:0]            waddr,
  input  logic [BYTE_W-1:0]           wdata,
  input  logic [IDX_W-1:0]            ridx,
  output logic [3:0][BYTE_W-1:0]      rd_bytes
);
  localparam int DEPTH = 2 ** IDX_W;

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];
    logic              lane_we;

    assign lane_we = we && (waddr[1:0] == 2'(l));

    always_ff @(posedge clk) begin
      if (lane_we) begin
        lane_mem[waddr[IDX_W+1:2]] <= wdata;
      end
    end

    assign rd_bytes[l] = lane_mem[ridx];
  end
endmodule

// File: rtl/pss_cfg.sv
module pss_cfg
  import pss_pkg::*;
#(
  parameter int          IDX_W = 6,
  parameter logic [7:0]  KEY_A = 8'hA5,
  parameter logic [7:0]  KEY_B = 8'h5A
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [REG_AW-1:0]           wr_addr,
  input  logic [7:0]                  wr_data,
  input  logic                        err_set,
  output logic [NEV-1:0][IDX_W-1:0]   start_ptr,
  output logic                        mem_we,
  output logic [IDX_W+1:0]            mem_addr,
  output logic [7:0]                  mem_wdata,
  output logic                        err_flag
);
  localparam int                MA_W    = IDX_W + 2;
  localparam logic [IDX_W-1:0]  END_IDX = {IDX_W{1'b1}};

  lock_e                      lock_q, lock_n;
  logic [NEV-1:0][IDX_W-1:0]  ptr_q, ptr_n;
  logic [MA_W-1:0]            maddr_q, maddr_n;
  logic                       err_q, err_n;
  logic                       open;
  logic                       clr_wr;

  assign open   = (lock_q == LK_OPEN);
  assign clr_wr = wr_en && (wr_addr == RA_ERRCLR);

  always_comb begin
    lock_n  = lock_q;
    ptr_n   = ptr_q;
    maddr_n = maddr_q;
    err_n   = err_q;
    mem_we  = 1'b0;
    if (wr_en) begin
      if (wr_addr == RA_KEY) begin
        if (wr_data == KEY_A) begin
          lock_n = LK_HALF;
        end else if (wr_data == KEY_B && lock_q == LK_HALF) begin
          lock_n = LK_OPEN;
        end else begin
          lock_n = LK_SHUT;
        end
      end
      if (open && wr_addr == RA_MADDR) begin
        maddr_n = wr_data[MA_W-1:0];
      end
      if (open && wr_addr == RA_MDATA) begin
        mem_we  = 1'b1;
        maddr_n = maddr_q + 1'b1;
      end
      for (int e = 0; e < NEV; e++) begin
        if (open && wr_addr == REG_AW'(RA_PTR0 + e)) begin
          ptr_n[e] = wr_data[IDX_W-1:0];
        end
      end
      if (wr_addr == RA_ERRCLR) begin
        err_n = 1'b0;
      end
    end
    if (err_set) begin
      err_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= LK_SHUT;
      ptr_q   <= {NEV{END_IDX}};
      maddr_q <= '0;
      err_q   <= 1'b0;
    end else begin
      lock_q  <= lock_n;
      ptr_q   <= ptr_n;
      maddr_q <= maddr_n;
      err_q   <= err_n;
    end
  end

  assign start_ptr = ptr_q;
  assign mem_addr  = maddr_q;
  assign mem_wdata = wr_data;
  assign err_flag  = err_q;

  AST_LOCKED_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !open && wr_addr != RA_KEY) |=> $stable(start_ptr)); // R2
  AST_MADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && open && wr_addr == RA_MDATA) |=> (mem_addr == $past(mem_addr) + 1'b1)); // R3
  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> err_flag); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr_wr) |=> err_flag); // R9
endmodule

// File: rtl/pss_engine.sv
module pss_engine
  import pss_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int DLY_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic [NEV-1:0]              trig,
  input  logic [NEV-1:0][IDX_W-1:0]   start_ptr,
  input  logic [15:0]                 rd_msg,
  input  logic [DLY_W-1:0]            rd_dly,
  input  logic [7:0]                  rd_nxt,
  output logic [IDX_W-1:0]            ridx,
  output logic                        msg_valid,
  output logic [15:0]                 msg_data,
  output logic                        busy,
  output logic                        done,
  output logic                        err_set
);
  localparam int                EV_W    = $clog2(NEV);
  localparam logic [IDX_W-1:0]  END_IDX = {IDX_W{1'b1}};

  eng_e              st_q, st_n;
  logic [IDX_W-1:0]  cur_q, cur_n;
  logic [IDX_W-1:0]  nxt_q, nxt_n;
  logic [DLY_W-1:0]  cnt_q, cnt_n;
  logic [EV_W-1:0]   sel;
  logic [EV_W:0]     nhit;
  logic              any_trig;

  always_comb begin
    sel  = '0;
    nhit = '0;
    for (int e = 0; e < NEV; e++) begin
      if (trig[e]) begin
        sel  = EV_W'(e);
        nhit = nhit + 1'b1;
      end
    end
  end

  assign any_trig = |trig;
  assign err_set  = any_trig && ((st_q != ENG_IDLE) || (nhit > 1));

  always_comb begin
    st_n  = st_q;
    cur_n = cur_q;
    nxt_n = nxt_q;
    cnt_n = cnt_q;
    unique case (st_q)
      ENG_IDLE: begin
        if (any_trig) begin
          cur_n = start_ptr[sel];
          st_n  = (start_ptr[sel] == END_IDX) ? ENG_FIN : ENG_EMIT;
        end
      end
      ENG_EMIT: begin
        cnt_n = rd_dly;
        nxt_n = rd_nxt[IDX_W-1:0];
        st_n  = ENG_WAIT;
      end
      ENG_WAIT: begin
        if (tick) begin
          if (cnt_q == '0) begin
            if (nxt_q == END_IDX) begin
              st_n = ENG_FIN;
            end else begin
              cur_n = nxt_q;
              st_n  = ENG_EMIT;
            end
          end else begin
            cnt_n = cnt_q - 1'b1;
          end
        end
      end
      ENG_FIN: begin
        st_n = ENG_IDLE;
      end
      default: st_n = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      cur_q <= END_IDX;
      nxt_q <= END_IDX;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cur_q <= cur_n;
      nxt_q <= nxt_n;
      cnt_q <= cnt_n;
    end
  end

  assign ridx      = cur_q;
  assign msg_valid = (st_q == ENG_EMIT);
  assign msg_data  = rd_msg;
  assign busy      = (st_q != ENG_IDLE);
  assign done      = (st_q == ENG_FIN);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> !msg_valid); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!msg_valid && !done)); // R1
  AST_WAIT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_WAIT && !tick) |=> (st_q == ENG_WAIT && $stable(cnt_q))); // R6
  AST_BUSY_KEEPS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_WAIT && any_trig) |=> $stable(nxt_q)); // R9
endmodule

// File: rtl/pwr_script_seq.sv
module pwr_script_seq
  import pss_pkg::*;
#(
  parameter int          IDX_W = 6,
  parameter int          DLY_W = 8,
  parameter logic [7:0]  KEY_A = 8'hA5,
  parameter logic [7:0]  KEY_B = 8'h5A
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [7:0]   wr_data,
  input  logic         tick,
  input  logic [3:0]   trig,
  output logic         msg_valid,
  output logic [15:0]  msg_data,
  output logic         busy,
  output logic         done,
  output logic         err_flag
);
  logic [NEV-1:0][IDX_W-1:0]  start_ptr;
  logic                       mem_we;
  logic [IDX_W+1:0]           mem_addr;
  logic [7:0]                 mem_wdata;
  logic                       err_set;
  logic [IDX_W-1:0]           ridx;
  logic [3:0][7:0]            rd_bytes;

  pss_cfg #(.IDX_W(IDX_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .err_set   (err_set),
    .start_ptr (start_ptr),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .err_flag  (err_flag)
  );

  pss_imem #(.IDX_W(IDX_W), .BYTE_W(8)) u_mem (
    .clk      (clk),
    .we       (mem_we),
    .waddr    (mem_addr),
    .wdata    (mem_wdata),
    .ridx     (ridx),
    .rd_bytes (rd_bytes)
  );

  pss_engine #(.IDX_W(IDX_W), .DLY_W(DLY_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .trig      (trig),
    .start_ptr (start_ptr),
    .rd_msg    ({rd_bytes[0], rd_bytes[1]}),
    .rd_dly    (DLY_W'(rd_bytes[2])),
    .rd_nxt    (rd_bytes[3]),
    .ridx      (ridx),
    .msg_valid (msg_valid),
    .msg_data  (msg_data),
    .busy      (busy),
    .done      (done),
    .err_set   (err_set)
  );
endmodule

// File: tb/sim_pwr_script_seq.sv
`timescale 1ns/1ps
module sim_pwr_script_seq;
  localparam int TDIV = 3;
  localparam logic [7:0] KA = 8'hA5;
  localparam logic [7:0] KB = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        tick = 1'b0;
  logic [3:0]  trig = '0;
  logic        msg_valid, busy, done, err_flag;
  logic [15:0] msg_data;

  pwr_script_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick(tick), .trig(trig), .msg_valid(msg_valid),
    .msg_data(msg_data), .busy(busy), .done(done), .err_flag(err_flag)
  );

  always #2 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // shadow model of the host-visible state
  logic [7:0] sm [256];
  int sptr [4];
  int smaddr = 0;
  int slk = 0;
  bit serr = 0;

  // slow tick generator
  int tdiv = 0;
  bit tick_on = 0;
  always @(posedge clk) begin
    #1;
    tdiv = (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    tick = tick_on && (tdiv == 0);
  end

  // monitor
  bit mon_on = 0;
  int tcnt = 0;
  int ngot = 0;
  int done_cnt = 0;
  int done_gap = 0;
  logic [15:0] gmsg [32];
  int ggap [32];
  always @(negedge clk) begin
    if (mon_on) begin
      if (msg_valid) begin
        if (ngot < 32) begin
          gmsg[ngot] = msg_data;
          ggap[ngot] = tcnt;
        end
        ngot++;
        tcnt = 0;
      end else if (done) begin
        done_gap = tcnt;
        done_cnt++;
        tcnt = 0;
      end else if (tick) begin
        tcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    case (a)
      3'd0: slk = (d == KA) ? 1 : ((d == KB && slk == 1) ? 2 : 0);
      3'd1: if (slk == 2) smaddr = d;
      3'd2: if (slk == 2) begin sm[smaddr] = d; smaddr = (smaddr + 1) % 256; end
      3'd7: serr = 0;
      default: if (slk == 2) sptr[a - 3] = d & 8'h3F;
    endcase
  endtask

  task automatic unlock();
    hw(3'd0, KA);
    hw(3'd0, KB);
  endtask

  task automatic load_ins(input int idx, input logic [15:0] m, input logic [7:0] dl,
                          input logic [7:0] nx);
    hw(3'd1, 8'(idx * 4));
    hw(3'd2, m[15:8]);
    hw(3'd2, m[7:0]);
    hw(3'd2, dl);
    hw(3'd2, nx);
  endtask

  // run one trigger mask; optionally intrude with a second trigger (and a clear)
  task automatic run_ev(input logic [3:0] mask, input logic [3:0] intr, input bit intr_clr,
                        input string tag);
    int e, n, idx, waited;
    logic [15:0] emsg [32];
    int edly [32];
    e = 0;
    for (int b = 0; b < 4; b++) if (mask[b]) e = b;
    n = 0;
    idx = sptr[e];
    while (idx != 63 && n < 32) begin
      emsg[n] = {sm[idx * 4], sm[idx * 4 + 1]};
      edly[n] = sm[idx * 4 + 2];
      idx = sm[idx * 4 + 3] & 8'h3F;
      n++;
    end
    if ($countones(mask) > 1) serr = 1;
    ngot = 0; done_cnt = 0; tcnt = 0; mon_on = 1;
    @(posedge clk); #1 trig = mask;
    @(posedge clk); #1 trig = '0;
    @(negedge clk);
    if (n == 0) begin
      chk(done == 1'b1, {tag, " R8 done next cycle"}, done, 1);
      chk(msg_valid == 1'b0, {tag, " R8 no message"}, msg_valid, 0);
    end else begin
      chk(msg_valid == 1'b1 && busy == 1'b1, {tag, " R5 first strobe timing"}, msg_valid, 1);
    end
    if (intr != 0) begin
      repeat (3) @(posedge clk);
      #1 trig = intr;
      if (intr_clr) begin wr_en = 1'b1; wr_addr = 3'd7; end
      @(posedge clk); #1 trig = '0; wr_en = 1'b0;
      serr = 1;
      @(negedge clk);
      chk(err_flag == 1'b1, {tag, " R9 error raised while busy"}, err_flag, 1);
    end
    waited = 0;
    while (done_cnt == 0 && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    chk(done_cnt == 1, {tag, " R7 done pulse seen"}, done_cnt, 1);
    chk(ngot == n, {tag, " R5 message count"}, ngot, n);
    for (int j = 0; j < n && j < ngot; j++) begin
      chk(gmsg[j] == emsg[j], {tag, " R3 message value"}, gmsg[j], emsg[j]);
      if (j > 0) chk(ggap[j] == edly[j - 1] + 1, {tag, " R6 tick gap"}, ggap[j], edly[j - 1] + 1);
    end
    if (n > 0) chk(done_gap == edly[n - 1] + 1, {tag, " R7 final gap"}, done_gap, edly[n - 1] + 1);
    @(negedge clk);
    mon_on = 0;
    chk(busy == 1'b0 && done == 1'b0, {tag, " R7 back to idle"}, busy, 0);
    chk(err_flag == serr, {tag, " R4 R9 error flag"}, err_flag, serr);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) sptr[i] = 63;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(msg_valid == 0, "R1 msg_valid", msg_valid, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(err_flag == 0, "R1 err_flag", err_flag, 0);
    tick_on = 1;

    // R2 locked: pointer write ignored, R1 pointer still at end marker
    hw(3'd3, 8'h2B);
    run_ev(4'b0001, 4'b0000, 0, "locked ptr0");
    // R2 wrong order: key B then key A leaves it half-open
    hw(3'd0, KB);
    hw(3'd0, KA);
    hw(3'd4, 8'h00);
    run_ev(4'b0010, 4'b0000, 0, "half-open ptr1");
    hw(3'd0, KB);

    // R3 R5 R6 sweep: one chain per event, lengths 1..4, delays 0..3
    begin
      int base;
      base = 8'h2B;
      for (int e = 0; e < 4; e++) begin
        for (int k = 0; k <= e; k++) begin
          load_ins(base + k, {4'(e), 4'(k), 8'(e * 37 + k * 11)}, 8'((e * 3 + k) % 4),
                   (k == e) ? 8'h3F : 8'(base + k + 1));
        end
        hw(3'(3 + e), 8'(base));
        base = base + e + 1;
      end
      for (int e = 0; e < 4; e++) run_ev(4'(1 << e), 4'b0000, 0, "sweep R4");
    end

    // R7 upper bits of next index ignored
    load_ins(5, 16'hBEEF, 8'd2, 8'hC9);
    load_ins(9, 16'h1234, 8'd1, 8'hFF);
    hw(3'd4, 8'd5);
    run_ev(4'b0010, 4'b0000, 0, "masked next R7");

    // R2 relock with 0: memory and pointer writes ignored
    hw(3'd0, 8'h00);
    hw(3'd1, 8'd20);
    hw(3'd2, 8'h77);
    hw(3'd4, 8'h2B);
    run_ev(4'b0010, 4'b0000, 0, "relocked R2");

    // R8 disabled event
    unlock();
    hw(3'd3, 8'h3F);
    run_ev(4'b0001, 4'b0000, 0, "disabled R8");

    // R9 trigger while busy, then clear
    run_ev(4'b1000, 4'b0001, 0, "intrude R9");
    hw(3'd7, 8'h00);
    @(negedge clk);
    chk(err_flag == 0, "R9 clear", err_flag, 0);

    // R4 simultaneous triggers: highest wins, error set
    run_ev(4'b0110, 4'b0000, 0, "simultaneous R4");
    hw(3'd7, 8'h00);

    // R9 clear and new error in the same cycle: set wins; clear works while locked
    run_ev(4'b1000, 4'b0010, 1, "clear-collide R9");
    hw(3'd0, 8'h00);
    hw(3'd7, 8'h00);
    @(negedge clk);
    chk(err_flag == 0, "R9 clear while locked", err_flag, 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule